// File: doc/BRIEF.md
# Word-to-Bit Serializer with Line Loopback

This block turns parallel words into a serial bit stream for a transmit front end. A modulo-16 timing counter advances once per serial bit time. It provides two things: a word clock for upstream logic to pace its transfers, and an internal strobe that moves a captured word into a loadable shift register. The shift register then sends the word out one bit per bit time, most significant bit first.

An output selector stands between the serializer and the transmit pins. With the active-low line-loopback select deasserted (high), the transmit data and clock come from the serializer. With it asserted (low), the received serial data and clock are passed straight through to the transmit side, which closes a receive-to-transmit loop for line testing.

The serial bit clock is modelled as a one-cycle enable on a single system clock. Every register therefore lives in one clock domain, and the transmit clock output reproduces that enable.

Top module: `word_serializer`

## Requirements
- R1: With loopback off, each word leaves on `tx_sdata` with bit 15 first and bit 0 last, one bit per enabled bit time.
- R2: `word_clk` has a period of 16 enabled bit times. It is low while the bit counter holds 0 to 7 and high while it holds 8 to 15. The counter starts at 0 after reset and advances by one on each enable.
- R3: On the enable where the counter holds 7 (the rising edge of `word_clk`), `par_word` is captured into the holding register. On the enable where the counter holds 15, the holding register is loaded into the shift register, so bit 15 of that word is on `tx_sdata` during the bit time that follows. Changes to `par_word` at other times have no effect.
- R4: On a cycle without `bit_en`, the counter, `word_clk` and the serial data do not change.
- R5: While `line_loop_n` is low, `tx_sdata` equals `rx_sdata` and `tx_sclk` equals `rx_sclk`, in the same cycle.
- R6: While `line_loop_n` is high, `tx_sclk` equals `bit_en`, and `tx_sdata` carries the shift register output.
- R7: While `rst_n` is low, `word_clk` is held low and the counter, holding register and shift register are cleared.
- R8: Between reset release and the first load, the serializer's data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Serial bit-time enable (models the serial bit clock) |
| par_word | input | 16 | Parallel word to transmit, bit 15 sent first |
| line_loop_n | input | 1 | Line-loopback select, active low |
| rx_sdata | input | 1 | Received serial data |
| rx_sclk | input | 1 | Received serial clock (enable form) |
| word_clk | output | 1 | Divide-by-16 word clock for upstream logic |
| tx_sdata | output | 1 | Transmit serial data |
| tx_sclk | output | 1 | Transmit serial clock (enable form) |

## Verification
The assertions assume the following about the inputs: `bit_en` is a synchronous single-cycle enable, `par_word` is settled on the enable that captures it, and reset is held for at least one clock edge. The stimulus drives every input half a cycle away from the active edge. It holds reset for several cycles, and it runs the enable both continuously and as sparse pulses, so the counter steps only on enabled cycles. It changes `par_word` on every cycle, not only at capture, which shows that only the counter-7 sample matters. It also drives the loopback inputs with random values while the local serializer keeps running underneath.

// File: rtl/ws_pkg.sv
package ws_pkg;

   localparam int WS_DEFAULT_WORD_W = 16;

   typedef enum logic {
      WS_PATH_LINE  = 1'b0,
      WS_PATH_LOCAL = 1'b1
   } ws_path_e;

endpackage

// File: rtl/ws_timing_gen.sv
module ws_timing_gen #(
   parameter int WORD_W = ws_pkg::WS_DEFAULT_WORD_W
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   output logic word_clk,
   output logic capture_stb,
   output logic load_stb
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(WORD_W / 2 - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bit_en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign word_clk    = cnt_q[CNT_W-1];
   assign capture_stb = bit_en && (cnt_q == CNT_HALF);
   assign load_stb    = bit_en && (cnt_q == CNT_LAST);

   assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(cnt_q));

   assert_wclk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_clk) |-> $past(capture_stb));

   assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> !load_stb);

endmodule

// File: rtl/ws_shift_out.sv
module ws_shift_out #(
   parameter int WORD_W    = ws_pkg::WS_DEFAULT_WORD_W,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              capture_stb,
   input  logic              load_stb,
   input  logic [WORD_W-1:0] par_word,
   output logic              serial_bit
);
   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (capture_stb) begin
         hold_q <= par_word;
      end
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_shifted = {sh_q[WORD_W-2:0], 1'b0};
         assign serial_bit = sh_q[WORD_W-1];

         assert_shift_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_en && !load_stb) |=> sh_q[WORD_W-1:1] == $past(sh_q[WORD_W-2:0]));
      end else begin : g_lsb
         assign sh_shifted = {1'b0, sh_q[WORD_W-1:1]};
         assign serial_bit = sh_q[0];

         assert_shift_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_en && !load_stb) |=> sh_q[WORD_W-2:0] == $past(sh_q[WORD_W-1:1]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load_stb) begin
         sh_q <= hold_q;
      end else if (bit_en) begin
         sh_q <= sh_shifted;
      end
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> sh_q == $past(hold_q));

   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capture_stb |=> hold_q == $past(par_word));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(sh_q));

endmodule

// File: rtl/ws_line_mux.sv
module ws_line_mux (
   input  ws_pkg::ws_path_e path_sel,
   input  logic             loc_data,
   input  logic             loc_clk,
   input  logic             line_data,
   input  logic             line_clk,
   output logic             out_data,
   output logic             out_clk
);
   always_comb begin
      unique case (path_sel)
         ws_pkg::WS_PATH_LINE: begin
            out_data = line_data;
            out_clk  = line_clk;
         end
         default: begin
            out_data = loc_data;
            out_clk  = loc_clk;
         end
      endcase
   end
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
   parameter int WORD_W    = ws_pkg::WS_DEFAULT_WORD_W,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] par_word,
   input  logic              line_loop_n,
   input  logic              rx_sdata,
   input  logic              rx_sclk,
   output logic              word_clk,
   output logic              tx_sdata,
   output logic              tx_sclk
);
   generate
      if (WORD_W < 4 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
         $error("word_serializer: WORD_W must be a power of two of at least 4");
      end
   endgenerate

   logic             capture_stb;
   logic             load_stb;
   logic             ser_bit;
   ws_pkg::ws_path_e path_sel;

   assign path_sel = line_loop_n ? ws_pkg::WS_PATH_LOCAL : ws_pkg::WS_PATH_LINE;

   ws_timing_gen #(.WORD_W(WORD_W)) u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .word_clk    (word_clk),
      .capture_stb (capture_stb),
      .load_stb    (load_stb)
   );

   ws_shift_out #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .capture_stb (capture_stb),
      .load_stb    (load_stb),
      .par_word    (par_word),
      .serial_bit  (ser_bit)
   );

   ws_line_mux u_mux (
      .path_sel  (path_sel),
      .loc_data  (ser_bit),
      .loc_clk   (bit_en),
      .line_data (rx_sdata),
      .line_clk  (rx_sclk),
      .out_data  (tx_sdata),
      .out_clk   (tx_sclk)
   );

   assert_loop_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !line_loop_n |-> (tx_sdata == rx_sdata) && (tx_sclk == rx_sclk));

   assert_local_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
      line_loop_n |-> (tx_sclk == bit_en) && (tx_sdata == ser_bit));

   assert_wclk_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(word_clk));

endmodule

// File: tb/word_serializer_test.sv
module word_serializer_test;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bit_en;
   logic [WORD_W-1:0] par_word;
   logic              line_loop_n;
   logic              rx_sdata;
   logic              rx_sclk;
   logic              word_clk;
   logic              tx_sdata;
   logic              tx_sclk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int  m_cnt;
   logic [WORD_W-1:0] m_hold;
   bit  m_q[$];
   bit  m_loaded;

   always #(CLK_PERIOD / 2) clk = ~clk;

   word_serializer uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .par_word    (par_word),
      .line_loop_n (line_loop_n),
      .rx_sdata    (rx_sdata),
      .rx_sclk     (rx_sclk),
      .word_clk    (word_clk),
      .tx_sdata    (tx_sdata),
      .tx_sclk     (tx_sclk)
   );

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic en, input logic [WORD_W-1:0] w, input logic lp,
                       input logic rd, input logic rc, input logic rst);
      logic exp_bit;
      string dtag;
      bit_en = en; par_word = w; line_loop_n = lp;
      rx_sdata = rd; rx_sclk = rc; rst_n = rst;
      @(posedge clk);
      if (!rst) begin
         m_cnt = 0; m_hold = '0; m_q.delete(); m_loaded = 1'b0;
      end else if (en) begin
         if (m_cnt == WORD_W - 1) begin
            m_q.delete();
            for (int i = WORD_W - 1; i >= 0; i--) m_q.push_back(m_hold[i]);
            m_loaded = 1'b1;
         end else if (m_q.size() > 0) begin
            void'(m_q.pop_front());
         end
         if (m_cnt == WORD_W / 2 - 1) m_hold = w;
         m_cnt = (m_cnt + 1) % WORD_W;
      end
      @(negedge clk);
      exp_bit = (m_q.size() > 0) ? m_q[0] : 1'b0;
      if (!rst) begin
         check_bit("R7", "word_clk in reset", word_clk, 1'b0);
         if (lp) check_bit("R7", "tx_sdata in reset", tx_sdata, 1'b0);
         return;
      end
      check_bit("R2", "word_clk", word_clk, (m_cnt >= WORD_W / 2));
      if (!lp) begin
         check_bit("R5", "looped tx_sdata", tx_sdata, rd);
         check_bit("R5", "looped tx_sclk", tx_sclk, rc);
      end else begin
         check_bit("R6", "local tx_sclk", tx_sclk, en);
         if (!en)                dtag = "R4";
         else if (!m_loaded)     dtag = "R8";
         else if (m_cnt == 0)    dtag = "R3";
         else                    dtag = "R1";
         check_bit(dtag, "local tx_sdata", tx_sdata, exp_bit);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [WORD_W-1:0] words [4];
      words[0] = 16'h8001; words[1] = 16'hFFFF; words[2] = 16'h0000; words[3] = 16'h1234;
      m_cnt = 0; m_hold = '0; m_loaded = 1'b0;

      // R7: reset state
      for (int k = 0; k < 3; k++) step(1'b1, 16'hDEAD, 1'b1, 1'b0, 1'b0, 1'b0);
      // R8: zeros until the first load
      for (int k = 0; k < 20; k++) step(1'b1, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b1);
      // R1, R3: fixed words, continuous enable
      for (int k = 0; k < 16 * 5; k++) step(1'b1, words[(k / 16) % 4], 1'b1, 1'b0, 1'b0, 1'b1);
      // R3: word changes every cycle, only the count-7 sample counts
      for (int k = 0; k < 64; k++) step(1'b1, WORD_W'($urandom), 1'b1, 1'b0, 1'b0, 1'b1);
      // R4: sparse enables
      for (int k = 0; k < 200; k++)
         step((k % 3) == 0, WORD_W'($urandom), 1'b1, 1'b1, 1'b1, 1'b1);
      // R5: line loopback with random receive traffic
      for (int k = 0; k < 60; k++)
         step(1'b1, WORD_W'($urandom), 1'b0, 1'($urandom), 1'($urandom), 1'b1);
      // Mixed
      for (int k = 0; k < 300; k++)
         step(($urandom % 4) != 0, WORD_W'($urandom), ($urandom % 8) != 0,
              1'($urandom), 1'($urandom), 1'b1);
      // R7: reset in mid-stream, then R8 again
      for (int k = 0; k < 2; k++) step(1'b1, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 40; k++) step(1'b1, 16'hC0DE, 1'b1, 1'b0, 1'b0, 1'b1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule